// File: doc/BRIEF.md
# Hypervisor-aware trap entry router

This block decides where a trap lands on a processor core that supports a hypervisor, and what the trap-entry hardware must write when it gets there. For each trap request it takes the raw cause, a flag that marks an interrupt, the current privilege level, the current virtualization flag, the trap value, the four delegation masks (machine exception, machine interrupt, hypervisor exception, hypervisor interrupt) and the three trap-vector bases (machine, hypervisor-supervisor, virtual-supervisor). From these it picks one of three targets: M, HS or VS.

It then reports the final cause code, the handler address, the next virtualization flag and the writes to the status fields that hold the previous virtualization state, the previous privilege of a guest and the guest-virtual-address flag. A request on `trap_valid_i` is captured at one clock edge. The results appear on the outputs one cycle later with a single-cycle `valid_o` pulse, and they stay unchanged until the next request. The surrounding trap logic uses these values to update the PC and the control registers.

Top module: `trap_entry`

## Requirements
- R1: While reset is held, and after it until the first request, `valid_o` and every result output are 0. A request sampled at a rising edge raises `valid_o` for exactly the following cycle, and the results of that request are on the outputs in that cycle.
- R2: A synchronous cause in the range 8 to 11 is an environment call. It is renumbered by privilege (encoding U=0, S=1, M=3): 11 from M, 10 from S while virtualized, 9 from S while not virtualized, 8 from U. The routing and the address that follow use the renumbered value.
- R3: The target is M (`tgt_o`=3) when the current privilege is M, or when the machine delegation bit at the cause index is 0. The interrupt mask is used for interrupts and the exception mask for exceptions.
- R4: The target is HS (`tgt_o`=1) when the machine delegation bit is set, the privilege is below M, and either the core is not virtualized or the hypervisor delegation bit for the same cause is 0.
- R5: The target is VS (`tgt_o`=2) only when the privilege is below M, the core is virtualized, and both the machine and the hypervisor delegation bits for the cause are set.
- R6: An interrupt routed to VS with cause 2, 6 or 10 leaves the block with its cause reduced by 1. All other cause values pass through unchanged.
- R7: The handler address is the base selected by the target (M, HS or VS) with its two low bits cleared. When the trap is an interrupt and the base's low two bits equal 1, four times the final cause is added. Mode values 0, 2 and 3 add nothing.
- R8: `virt_o` is 1 exactly when the target is VS.
- R9: For an HS target, `hs_upd_o`=1 and `spv_o` equals the incoming virtualization flag. `spvp_we_o` is 1 only when the core was virtualized, and `spvp_o` then carries privilege bit 0. For other targets, `hs_upd_o`=0 and `spvp_we_o`=0.
- R10: For an M target, `m_upd_o`=1, `mpv_o` equals the incoming virtualization flag, and `gva_o` is 1 exactly when the core was virtualized and the trap value is nonzero. For other targets, `m_upd_o`=0.
- R11: In cycles without a request, every result output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | Trap request, sampled at the rising edge |
| async_i | input | 1 | 1 for interrupt, 0 for exception |
| cause_i | input | CAUSE_W | Raw cause code |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Current virtualization flag |
| tval_i | input | XLEN | Trap value |
| medeleg_i | input | 2**CAUSE_W | Machine exception delegation mask |
| mideleg_i | input | 2**CAUSE_W | Machine interrupt delegation mask |
| hedeleg_i | input | 2**CAUSE_W | Hypervisor exception delegation mask |
| hideleg_i | input | 2**CAUSE_W | Hypervisor interrupt delegation mask |
| mtvec_i | input | XLEN | M-level vector base and mode |
| stvec_i | input | XLEN | HS-level vector base and mode |
| vstvec_i | input | XLEN | VS-level vector base and mode |
| valid_o | output | 1 | Result pulse |
| tgt_o | output | 2 | Target (HS=1, VS=2, M=3) |
| cause_o | output | CAUSE_W | Final cause code |
| pc_o | output | XLEN | Handler address |
| virt_o | output | 1 | Next virtualization flag |
| hs_upd_o | output | 1 | HS status update strobe |
| spv_o | output | 1 | Previous-virtualization value for HS |
| spvp_we_o | output | 1 | Guest previous-privilege write enable |
| spvp_o | output | 1 | Guest previous-privilege value |
| m_upd_o | output | 1 | M status update strobe |
| mpv_o | output | 1 | Previous-virtualization value for M |
| gva_o | output | 1 | Guest-virtual-address flag |

## Verification
The assertions check, on every cycle, the properties that hold for any input: a result pulse always follows a request, a trap from M never leaves M, VS is never chosen without virtualization, exceptions produce an aligned address, `virt_o` tracks a VS target, the HS and M update strobes never both fire, and results hold between requests. Other behaviour depends on the actual mask and base values, and only the bench's scenarios can show it. This covers the environment-call renumbering, the three-way choice for each delegation pattern, the VS interrupt renumbering, the vectored offset and its reserved mode values, and the exact status-field values.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_HS   = 2'd1,
    TGT_VS   = 2'd2,
    TGT_M    = 2'd3
  } tgt_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int CAUSE_W = 6,
  localparam int DW = 1 << CAUSE_W
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic [DW-1:0]      medeleg_i,
  input  logic [DW-1:0]      mideleg_i,
  input  logic [DW-1:0]      hedeleg_i,
  input  logic [DW-1:0]      hideleg_i,
  output tgt_e               tgt_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] ecall_cause, base_cause;
  logic               is_ecall, m_bit, h_bit, to_s, to_vs, vs_irq;

  assign is_ecall = !async_i && (cause_i >= CAUSE_W'(8)) && (cause_i <= CAUSE_W'(11));

  always_comb begin
    if (priv_i == PRIV_M)      ecall_cause = CAUSE_W'(11);
    else if (priv_i == PRIV_S) ecall_cause = virt_i ? CAUSE_W'(10) : CAUSE_W'(9);
    else                       ecall_cause = CAUSE_W'(8);
  end

  assign base_cause = is_ecall ? ecall_cause : cause_i;

  assign m_bit = async_i ? mideleg_i[base_cause] : medeleg_i[base_cause];
  assign h_bit = async_i ? hideleg_i[base_cause] : hedeleg_i[base_cause];
  assign to_s  = (priv_i != PRIV_M) && m_bit;
  assign to_vs = to_s && virt_i && h_bit;

  always_comb begin
    if (to_vs)     tgt_o = TGT_VS;
    else if (to_s) tgt_o = TGT_HS;
    else           tgt_o = TGT_M;
  end

  // guest-level interrupts appear to the guest as their supervisor-level codes
  assign vs_irq = async_i && to_vs &&
                  (base_cause == CAUSE_W'(2) || base_cause == CAUSE_W'(6) ||
                   base_cause == CAUSE_W'(10));
  assign cause_o = vs_irq ? base_cause - CAUSE_W'(1) : base_cause;
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  tgt_e               tgt_i,
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    mtvec_i,
  input  logic [XLEN-1:0]    stvec_i,
  input  logic [XLEN-1:0]    vstvec_i,
  output logic [XLEN-1:0]    pc_o
);
  logic [XLEN-1:0] base, offs;

  always_comb begin
    unique case (tgt_i)
      TGT_VS:  base = vstvec_i;
      TGT_HS:  base = stvec_i;
      default: base = mtvec_i;
    endcase
  end

  assign offs = (async_i && base[1:0] == 2'b01)
              ? {{(XLEN-CAUSE_W-2){1'b0}}, cause_i, 2'b00} : '0;
  assign pc_o = {base[XLEN-1:2], 2'b00} + offs;
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6,
  localparam int DW = 1 << CAUSE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic [XLEN-1:0]    tval_i,
  input  logic [DW-1:0]      medeleg_i,
  input  logic [DW-1:0]      mideleg_i,
  input  logic [DW-1:0]      hedeleg_i,
  input  logic [DW-1:0]      hideleg_i,
  input  logic [XLEN-1:0]    mtvec_i,
  input  logic [XLEN-1:0]    stvec_i,
  input  logic [XLEN-1:0]    vstvec_i,
  output logic               valid_o,
  output logic [1:0]         tgt_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               virt_o,
  output logic               hs_upd_o,
  output logic               spv_o,
  output logic               spvp_we_o,
  output logic               spvp_o,
  output logic               m_upd_o,
  output logic               mpv_o,
  output logic               gva_o
);
  tgt_e               tgt_n;
  logic [CAUSE_W-1:0] cause_n;
  logic [XLEN-1:0]    pc_n;

  trap_route #(.CAUSE_W(CAUSE_W)) u_route (
    .async_i   (async_i),
    .cause_i   (cause_i),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .medeleg_i (medeleg_i),
    .mideleg_i (mideleg_i),
    .hedeleg_i (hedeleg_i),
    .hideleg_i (hideleg_i),
    .tgt_o     (tgt_n),
    .cause_o   (cause_n)
  );

  trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .tgt_i    (tgt_n),
    .async_i  (async_i),
    .cause_i  (cause_n),
    .mtvec_i  (mtvec_i),
    .stvec_i  (stvec_i),
    .vstvec_i (vstvec_i),
    .pc_o     (pc_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      tgt_o     <= '0;
      cause_o   <= '0;
      pc_o      <= '0;
      virt_o    <= 1'b0;
      hs_upd_o  <= 1'b0;
      spv_o     <= 1'b0;
      spvp_we_o <= 1'b0;
      spvp_o    <= 1'b0;
      m_upd_o   <= 1'b0;
      mpv_o     <= 1'b0;
      gva_o     <= 1'b0;
    end else begin
      valid_o <= trap_valid_i;
      if (trap_valid_i) begin
        tgt_o     <= tgt_n;
        cause_o   <= cause_n;
        pc_o      <= pc_n;
        virt_o    <= (tgt_n == TGT_VS);
        hs_upd_o  <= (tgt_n == TGT_HS);
        spv_o     <= (tgt_n == TGT_HS) && virt_i;
        spvp_we_o <= (tgt_n == TGT_HS) && virt_i;
        spvp_o    <= (tgt_n == TGT_HS) && virt_i && priv_i[0];
        m_upd_o   <= (tgt_n == TGT_M);
        mpv_o     <= (tgt_n == TGT_M) && virt_i;
        gva_o     <= (tgt_n == TGT_M) && virt_i && (tval_i != '0);
      end
    end
  end

  p_valid_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(trap_valid_i));

  p_m_stays_m_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_i == PRIV_M) |=> (tgt_o == TGT_M));

  p_vs_needs_virt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !virt_i) |=> (tgt_o != TGT_VS));

  p_sync_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !async_i) |=> (pc_o[1:0] == 2'b00));

  p_virt_vs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (virt_o == (tgt_o == TGT_VS)));

  p_upd_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hs_upd_o, m_upd_o}));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> ($stable(pc_o) && $stable(cause_o) && $stable(tgt_o)));
endmodule

// File: tb/sim_trap_entry.sv
module sim_trap_entry;
  localparam int XLEN = 32;
  localparam int CW   = 6;
  localparam int DW   = 1 << CW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trap_valid_i = 1'b0, async_i = 1'b0, virt_i = 1'b0;
  logic [CW-1:0] cause_i = '0;
  logic [1:0] priv_i = '0;
  logic [XLEN-1:0] tval_i = '0;
  logic [DW-1:0] medeleg_i, mideleg_i, hedeleg_i, hideleg_i;
  logic [XLEN-1:0] mtvec_i, stvec_i, vstvec_i;
  logic valid_o, virt_o, hs_upd_o, spv_o, spvp_we_o, spvp_o, m_upd_o, mpv_o, gva_o;
  logic [1:0] tgt_o;
  logic [CW-1:0] cause_o;
  logic [XLEN-1:0] pc_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  trap_entry #(.XLEN(XLEN), .CAUSE_W(CW)) u0 (.*);

  typedef struct packed {
    logic        as;
    logic [5:0]  c;
    logic [1:0]  p;
    logic        v;
    logic        tz;
    logic [1:0]  et;
    logic [5:0]  ec;
    logic [31:0] epc;
  } vec_t;

  // targets: 1=HS 2=VS 3=M
  localparam vec_t VT [16] = '{
    '{1'b0, 6'd8,  2'd0, 1'b0, 1'b0, 2'd1, 6'd8,  32'h2000}, // R2 R4 ecall U
    '{1'b0, 6'd8,  2'd1, 1'b1, 1'b0, 2'd1, 6'd10, 32'h2000}, // R2 virt S ecall
    '{1'b0, 6'd8,  2'd3, 1'b0, 1'b0, 2'd3, 6'd11, 32'h1000}, // R2 R3 M ecall
    '{1'b0, 6'd8,  2'd1, 1'b0, 1'b0, 2'd3, 6'd9,  32'h1000}, // R2 R3 not delegated
    '{1'b0, 6'd13, 2'd0, 1'b1, 1'b1, 2'd2, 6'd13, 32'h3000}, // R5 sync to VS
    '{1'b1, 6'd10, 2'd1, 1'b1, 1'b0, 2'd2, 6'd9,  32'h3024}, // R6 R7
    '{1'b1, 6'd6,  2'd0, 1'b1, 1'b0, 2'd2, 6'd5,  32'h3014}, // R6 R7
    '{1'b1, 6'd5,  2'd1, 1'b1, 1'b0, 2'd1, 6'd5,  32'h2000}, // R4 direct mode
    '{1'b1, 6'd7,  2'd0, 1'b1, 1'b1, 2'd3, 6'd7,  32'h101C}, // R3 R10 vectored M
    '{1'b1, 6'd10, 2'd3, 1'b0, 1'b0, 2'd3, 6'd10, 32'h1028}, // R3 priv M blocks
    '{1'b0, 6'd13, 2'd1, 1'b0, 1'b0, 2'd1, 6'd13, 32'h2000}, // R4 R9 not virt
    '{1'b1, 6'd2,  2'd0, 1'b0, 1'b0, 2'd1, 6'd2,  32'h2000}, // R6 no renumber in HS
    '{1'b0, 6'd2,  2'd0, 1'b1, 1'b1, 2'd1, 6'd2,  32'h2000}, // R4 hyp bit clear
    '{1'b0, 6'd1,  2'd1, 1'b1, 1'b1, 2'd3, 6'd1,  32'h1000}, // R10 gva set
    '{1'b0, 6'd1,  2'd1, 1'b1, 1'b0, 2'd3, 6'd1,  32'h1000}, // R10 gva clear
    '{1'b0, 6'd9,  2'd0, 1'b1, 1'b0, 2'd2, 6'd8,  32'h3000}  // R2 R5 ecall to VS
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic as, input logic [5:0] c, input logic [1:0] p,
                      input logic v, input logic tz);
    @(negedge clk_i);
    trap_valid_i = 1'b1;
    async_i = as; cause_i = c; priv_i = p; virt_i = v;
    tval_i = tz ? 32'hDEAD_0000 : '0;
    @(negedge clk_i);
    trap_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    medeleg_i = '0; medeleg_i[2] = 1'b1; medeleg_i[8] = 1'b1;
    medeleg_i[10] = 1'b1; medeleg_i[13] = 1'b1;
    hedeleg_i = '0; hedeleg_i[8] = 1'b1; hedeleg_i[13] = 1'b1;
    mideleg_i = DW'(64'h666);
    hideleg_i = DW'(64'h444);
    mtvec_i = 32'h1001; stvec_i = 32'h2000; vstvec_i = 32'h3001;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 pc in reset", pc_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 tgt after reset", tgt_o, 0);

    for (int i = 0; i < 16; i++) begin
      fire(VT[i].as, VT[i].c, VT[i].p, VT[i].v, VT[i].tz);
      chk("R1 valid pulse", valid_o, 1);
      chk("R3 R4 R5 target", tgt_o, VT[i].et);
      chk("R2 R6 cause", cause_o, VT[i].ec);
      chk("R7 pc", pc_o, VT[i].epc);
      chk("R8 virt", virt_o, VT[i].et == 2'd2);
      chk("R9 hs_upd", hs_upd_o, VT[i].et == 2'd1);
      chk("R9 spvp_we", spvp_we_o, VT[i].et == 2'd1 && VT[i].v);
      if (VT[i].et == 2'd1) begin
        chk("R9 spv", spv_o, VT[i].v);
        if (VT[i].v) chk("R9 spvp", spvp_o, VT[i].p[0]);
      end
      chk("R10 m_upd", m_upd_o, VT[i].et == 2'd3);
      if (VT[i].et == 2'd3) begin
        chk("R10 mpv", mpv_o, VT[i].v);
        chk("R10 gva", gva_o, VT[i].v && VT[i].tz);
      end
      @(negedge clk_i);
      chk("R1 pulse ends", valid_o, 0);
    end

    // R7 reserved mode 3 adds no offset
    mtvec_i = 32'h1003;
    fire(1'b1, 6'd7, 2'd3, 1'b0, 1'b0);
    chk("R7 mode3 pc", pc_o, 32'h1000);
    // R7 mode 2 as well
    mtvec_i = 32'h1002;
    fire(1'b1, 6'd11, 2'd3, 1'b0, 1'b0);
    chk("R7 mode2 pc", pc_o, 32'h1000);
    mtvec_i = 32'h1001;

    // R11 hold: inputs change without request
    fire(1'b1, 6'd10, 2'd1, 1'b1, 1'b0);
    async_i = 1'b0; cause_i = 6'd1; priv_i = 2'd3; virt_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R11 valid low", valid_o, 0);
    chk("R11 pc held", pc_o, 32'h3024);
    chk("R11 cause held", cause_o, 9);
    chk("R11 tgt held", tgt_o, 2);

    // R1 back-to-back requests
    @(negedge clk_i);
    trap_valid_i = 1'b1; async_i = 1'b0; cause_i = 6'd8; priv_i = 2'd3; virt_i = 1'b0;
    @(negedge clk_i);
    chk("R1 b2b first", cause_o, 11);
    priv_i = 2'd0;
    @(negedge clk_i);
    trap_valid_i = 1'b0;
    chk("R1 b2b second", cause_o, 8);
    chk("R1 b2b valid", valid_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule